// File: doc/BRIEF.md
# Masked Pattern-Match and Change-of-State Event Detector

This block watches two 8-bit input ports and produces event pulses for the interrupt control logic. The first port goes to a pattern detector. It raises an event when every line selected by its mask equals the programmed reference value. The second port goes to a change detector. It raises an event when any line selected by its own mask changes level.

Both ports first pass through a two-flop synchronizer. The host programs three 8-bit registers through a plain write strobe with a 2-bit register selector:

| Selector | Register |
|---|---|
| 0 | Reference value |
| 1 | Pattern mask |
| 2 | Change mask |
| 3 | No register (the write is dropped) |

The outputs are single-cycle pulses. They carry no payload and have no handshake, so there is no back-pressure. A pulse is meant to be captured by a flag register downstream in the same cycle it is high.

Top module: `dio_event_detector`

## Requirements
- R1: After reset both event outputs are low, and all three registers are cleared. Input activity therefore produces no event until the host programs a mask.
- R2: When the synchronized pattern port starts to match the reference on every enabled bit, `match_evt` goes high for exactly one cycle. Take the input change as being applied between clock edges. The pulse is high after the third rising edge that follows that change.
- R3: Bits whose pattern-mask bit is 0 are left out of the comparison. Their level neither creates a match nor breaks one.
- R4: `match_evt` pulses only when the match condition turns from false to true. While the match holds there is no further pulse. Leaving the match and entering it again produces a new pulse.
- R5: While the pattern mask is all zero, `match_evt` never asserts, whatever the port level.
- R6: A level change on one or more enabled bits of the change port gives one single-cycle pulse on `chg_evt`. It has the same three-edge latency as R2. Several bits changing together give one pulse.
- R7: Toggles on bits whose change-mask bit is 0 give no event. For example, with only bits 1, 2, 6 and 7 enabled, a toggle of bit 3 gives no pulse.
- R8: A write to the change mask reloads the previous-value register. A change that reaches the compare point in the same cycle as that accepted write is absorbed and produces no pulse.
- R9: Selector value 3 writes nothing. The reference value and both masks keep their contents.
- R10: The two detectors work independently. `match_evt` and `chg_evt` can both be high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pa_pins | input | 8 | Port watched by the pattern detector (asynchronous) |
| pb_pins | input | 8 | Port watched by the change detector (asynchronous) |
| cfg_we | input | 1 | Host register write strobe |
| cfg_sel | input | 2 | Register selector: 0 reference value, 1 pattern mask, 2 change mask, 3 none |
| cfg_wdata | input | 8 | Host write data |
| match_evt | output | 1 | Single-cycle pattern-match event |
| chg_evt | output | 1 | Single-cycle change-of-state event |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the two detectors. The bench drives a matching value on the pattern port and a new value on the change port at the same instant. It then expects both pulses high together, three edges later.

The second pair is the change detector's compare and a change-mask write. The bench times the mask write so that it is accepted exactly in the cycle when a fresh enabled change reaches the compare point. The absorb rule is judged by `chg_evt` staying low in that cycle and in every cycle after it.

// File: rtl/dio_evt_pkg.sv
package dio_evt_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    SEL_REF_VAL  = 2'd0,
    SEL_PAT_MASK = 2'd1,
    SEL_CHG_MASK = 2'd2,
    SEL_NONE     = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [PORT_W-1:0] ref_val;
    logic [PORT_W-1:0] pat_mask;
    logic [PORT_W-1:0] chg_mask;
  } det_cfg_t;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[LAST];
endmodule

// File: rtl/dio_cfg_regs.sv
module dio_cfg_regs
  import dio_evt_pkg::*;
#(
  parameter int unsigned WIDTH = PORT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  cfg_sel_e         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] ref_val,
  output logic [WIDTH-1:0] pat_mask,
  output logic [WIDTH-1:0] chg_mask,
  output logic             chg_mask_wr
);
  logic [WIDTH-1:0] ref_q, pmask_q, cmask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= '0;
      pmask_q <= '0;
      cmask_q <= '0;
    end else if (we) begin
      unique case (sel)
        SEL_REF_VAL:  ref_q   <= wdata;
        SEL_PAT_MASK: pmask_q <= wdata;
        SEL_CHG_MASK: cmask_q <= wdata;
        default: ;
      endcase
    end
  end

  assign ref_val     = ref_q;
  assign pat_mask    = pmask_q;
  assign chg_mask    = cmask_q;
  assign chg_mask_wr = we && (sel == SEL_CHG_MASK);
endmodule

// File: rtl/dio_pat_det.sv
module dio_pat_det #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sample,
  input  logic [WIDTH-1:0] ref_val,
  input  logic [WIDTH-1:0] mask,
  output logic             evt
);
  logic [WIDTH-1:0] miss;
  logic             hit_now, hit_q, evt_q;

  assign miss    = (sample ^ ref_val) & mask;
  assign hit_now = (mask != '0) && (miss == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      hit_q <= hit_now;
      evt_q <= hit_now && !hit_q;
    end
  end

  assign evt = evt_q;
endmodule

// File: rtl/dio_cos_det.sv
module dio_cos_det #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sample,
  input  logic [WIDTH-1:0] mask,
  input  logic             absorb,
  output logic [WIDTH-1:0] prev,
  output logic             evt
);
  logic [WIDTH-1:0] prev_q, diff;
  logic             evt_q;

  assign diff = (sample ^ prev_q) & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      prev_q <= sample;
      evt_q  <= (diff != '0) && !absorb;
    end
  end

  assign prev = prev_q;
  assign evt  = evt_q;
endmodule

// File: rtl/dio_event_detector.sv
module dio_event_detector
  import dio_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pa_pins,
  input  logic [PORT_W-1:0] pb_pins,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [PORT_W-1:0] cfg_wdata,
  output logic              match_evt,
  output logic              chg_evt
);
  logic [PORT_W-1:0] pa_sync, pb_sync, pb_prev;
  logic              chg_mask_wr;
  det_cfg_t          cfg;

  dio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst_n(rst_n), .async_in(pa_pins), .sync_out(pa_sync)
  );

  dio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst_n(rst_n), .async_in(pb_pins), .sync_out(pb_sync)
  );

  dio_cfg_regs #(.WIDTH(PORT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel_e'(cfg_sel)),
    .wdata(cfg_wdata), .ref_val(cfg.ref_val), .pat_mask(cfg.pat_mask),
    .chg_mask(cfg.chg_mask), .chg_mask_wr(chg_mask_wr)
  );

  dio_pat_det #(.WIDTH(PORT_W)) u_pat (
    .clk(clk), .rst_n(rst_n), .sample(pa_sync), .ref_val(cfg.ref_val),
    .mask(cfg.pat_mask), .evt(match_evt)
  );

  dio_cos_det #(.WIDTH(PORT_W)) u_cos (
    .clk(clk), .rst_n(rst_n), .sample(pb_sync), .mask(cfg.chg_mask),
    .absorb(chg_mask_wr), .prev(pb_prev), .evt(chg_evt)
  );
endmodule

// File: rtl/dio_event_checker.sv
module dio_event_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] pa_sync,
  input logic [WIDTH-1:0] pb_sync,
  input logic [WIDTH-1:0] ref_val,
  input logic [WIDTH-1:0] pat_mask,
  input logic [WIDTH-1:0] chg_mask,
  input logic             chg_mask_wr,
  input logic             match_evt,
  input logic             chg_evt
);
  // R2 and R3: a pulse follows a cycle where the enabled bits agreed.
  assert_match_agrees_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |-> (($past(pa_sync) ^ $past(ref_val)) & $past(pat_mask)) == '0);

  assert_match_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> !match_evt);

  assert_zero_mask_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |-> $past(pat_mask) != '0);

  assert_chg_needs_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |-> $past(pb_sync) != $past(pb_sync, 2));

  assert_chg_needs_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |-> $past(chg_mask) != '0);

  assert_write_absorbs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chg_mask_wr) |-> !chg_evt);
endmodule

bind dio_event_detector dio_event_checker #(.WIDTH(dio_evt_pkg::PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pa_sync(pa_sync), .pb_sync(pb_sync),
  .ref_val(cfg.ref_val), .pat_mask(cfg.pat_mask), .chg_mask(cfg.chg_mask),
  .chg_mask_wr(chg_mask_wr), .match_evt(match_evt), .chg_evt(chg_evt)
);

// File: tb/tb_dio_event_detector.sv
module tb_dio_event_detector;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] S_REF = 2'd0, S_PM = 2'd1, S_CM = 2'd2, S_NONE = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pa_pins = '0, pb_pins = '0, cfg_wdata = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic       match_evt, chg_evt;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  dio_event_detector dut (
    .clk(clk), .rst_n(rst_n), .pa_pins(pa_pins), .pb_pins(pb_pins),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .match_evt(match_evt), .chg_evt(chg_evt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Called at a negedge; write lands on the following posedge.
  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic window(input int n, output int mc, output int cc);
    mc = 0; cc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mc += int'(match_evt);
      cc += int'(chg_evt);
    end
  endtask

  task automatic lat3();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    int mc, cc;
    check("R1 match after reset", int'(match_evt), 0);
    check("R1 chg after reset", int'(chg_evt), 0);
    pa_pins = 8'h00; pb_pins = 8'hFF;
    window(8, mc, cc);
    check("R1 no match with cleared regs", mc, 0);
    check("R1 no chg with cleared regs", cc, 0);
    pb_pins = 8'h00;
    window(6, mc, cc);
  endtask

  task automatic t_match_basic();
    int mc, cc;
    cfg_write(S_REF, 8'hA5); cfg_write(S_PM, 8'hFF);
    pa_pins = 8'h00; window(6, mc, cc);
    pa_pins = 8'hA5; lat3();
    check("R2 match pulse at latency", int'(match_evt), 1);
    @(negedge clk);
    check("R2 match pulse one cycle", int'(match_evt), 0);
  endtask

  task automatic t_match_mask();
    int mc, cc;
    cfg_write(S_PM, 8'h0F); cfg_write(S_REF, 8'h05);
    pa_pins = 8'h00; window(6, mc, cc);
    pa_pins = 8'hF5; lat3();
    check("R3 match with disabled bits differing", int'(match_evt), 1);
    pa_pins = 8'h35; window(6, mc, cc);
    check("R3 disabled bits do not retrigger", mc, 0);
  endtask

  task automatic t_match_once();
    int mc, cc;
    window(10, mc, cc);
    check("R4 held match gives no pulse", mc, 0);
    pa_pins = 8'h00; window(6, mc, cc);
    check("R4 leaving match gives no pulse", mc, 0);
    pa_pins = 8'h05; window(6, mc, cc);
    check("R4 re-entry pulses once", mc, 1);
  endtask

  task automatic t_zero_mask();
    int mc, cc, tot;
    cfg_write(S_PM, 8'h00); cfg_write(S_REF, 8'h00);
    tot = 0;
    for (int v = 0; v < 6; v++) begin
      pa_pins = 8'(v * 37);
      window(4, mc, cc);
      tot += mc;
    end
    check("R5 zero mask never matches", tot, 0);
  endtask

  task automatic t_sel_none();
    int mc, cc;
    cfg_write(S_PM, 8'hFF); cfg_write(S_REF, 8'h3C);
    pa_pins = 8'h00; window(6, mc, cc);
    cfg_write(S_NONE, 8'h00);
    pa_pins = 8'h3C; window(6, mc, cc);
    check("R9 selector 3 leaves reference value", mc, 1);
    pb_pins = 8'hFF; window(6, mc, cc);
    check("R9 selector 3 leaves change mask", cc, 0);
    pb_pins = 8'h00; window(6, mc, cc);
  endtask

  task automatic t_cos_basic();
    int mc, cc;
    cfg_write(S_CM, 8'hFF);
    pb_pins = 8'h00; window(6, mc, cc);
    pb_pins = 8'h81; lat3();
    check("R6 chg pulse at latency", int'(chg_evt), 1);
    window(6, mc, cc);
    check("R6 multi-bit change gives one pulse", cc, 0);
  endtask

  task automatic t_cos_masked();
    int mc, cc;
    cfg_write(S_CM, 8'hC6);
    pb_pins = 8'h00; window(6, mc, cc);
    pb_pins = 8'h08; window(6, mc, cc);
    check("R7 disabled bit 3 toggle ignored", cc, 0);
    pb_pins = 8'h0C; lat3();
    check("R7 enabled bit 2 toggle seen", int'(chg_evt), 1);
  endtask

  task automatic t_cos_absorb();
    int mc, cc;
    cfg_write(S_CM, 8'hFF);
    pb_pins = 8'h00; window(6, mc, cc);
    pb_pins = 8'h10;
    repeat (2) @(negedge clk);
    cfg_write(S_CM, 8'hFF);
    check("R8 change absorbed in write cycle", int'(chg_evt), 0);
    window(6, mc, cc);
    check("R8 no late event after write", cc, 0);
  endtask

  task automatic t_both();
    int mc, cc;
    cfg_write(S_PM, 8'hFF); cfg_write(S_REF, 8'h77);
    pa_pins = 8'h00; pb_pins = 8'h00; window(6, mc, cc);
    pa_pins = 8'h77; pb_pins = 8'h55; lat3();
    check("R10 match in shared cycle", int'(match_evt), 1);
    check("R10 chg in shared cycle", int'(chg_evt), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_match_basic();
    t_match_mask();
    t_match_once();
    t_zero_mask();
    t_sel_none();
    t_cos_basic();
    t_cos_masked();
    t_cos_absorb();
    t_both();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule